// File: doc/BRIEF.md
# Count-compare timer interrupt

This block keeps a free-running event counter and a compare value, and raises a timer-pending level when the counter crosses the compare value. Each cycle the core may report a retire event that carries a retire count. That count can be larger than one, so one step can move the counter well past the compare value. The crossing test works on the low bits of the counter, cut to the width of the compare register. It therefore catches a compare value that a multi-count step jumps over as well as one it lands on exactly.

Software reaches the block through a single control-register write port. Four different addresses all load the same counter. A fifth address loads the compare value and also re-arms the timer, which clears the pending level. Once raised, the pending level stays high until compare is written again, even when the counter keeps running past compare. The pending level is held by a two-state machine. TS_ARMED goes to TS_FIRED on a detected crossing. TS_FIRED goes back to TS_ARMED on a compare write. In TS_ARMED a compare write keeps the machine in TS_ARMED. The interrupt controller that consumes the pending level lies outside this block.

Top module: `tcmp_timer`

## Requirements
- R1: While reset is asserted, and on release, the counter, the compare value and the pending level are all zero.
- R2: A cycle with `retire_valid` high and no counter write adds `retire_num` (0 to 15) to the 64-bit counter, which wraps modulo 2^64. A cycle with neither has no effect on the counter.
- R3: A write (`csr_we` high) to address 0xC00, 0xC01, 0xC02 or 0x7C0 loads `csr_wdata` into the counter on the next cycle. A write to any address other than these four and 0x7C1 changes nothing.
- R4: A counter write in the same cycle as a retire event wins: the counter takes `csr_wdata` and the retire count is dropped.
- R5: On a retire step without a counter write, let L be the counter's low 32 bits before the step. The pending level goes high on the next cycle when L <= compare and L + `retire_num`, summed without truncation, >= compare. This includes a step of zero that starts with L equal to compare.
- R6: Counter bits 63:32 have no influence on crossing detection.
- R7: A step that starts with L above compare does not raise the pending level, even if the 32-bit sum wraps past compare.
- R8: A write to address 0x7C1 loads `csr_wdata[31:0]` into compare and drives the pending level low on the next cycle. This holds even if a crossing is detected in the same cycle.
- R9: Once high, the pending level stays high until a compare write, including when the counter moves beyond compare.
- R10: A counter write never raises the pending level, even when it loads the compare value exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_valid | input | 1 | Retire event strobe |
| retire_num | input | 4 | Number of events retired in this cycle |
| csr_we | input | 1 | Control-register write enable |
| csr_addr | input | 12 | Control-register write address |
| csr_wdata | input | 64 | Control-register write data |
| count_o | output | 64 | Current counter value |
| compare_o | output | 32 | Current compare value |
| timer_pend_o | output | 1 | Timer-pending level |

## Verification
The bench targets a multi-count step that jumps over compare without landing on it. A design that only tests equality would miss this step and leave the pending level low. It also drives steps whose low word is above compare and wraps past it, and counters whose upper word is nonzero. A design that compared all 64 bits, or compared after truncating the sum, would raise or miss the level in those cases. Same-cycle collisions come next: counter write against retire, and compare write against a crossing. A wrong priority there shows up as a counter that carries the extra count, or as a pending level that survives re-arming. Last, it keeps retiring past compare and loads the counter to exactly the compare value. A design that cleared the level on passing compare, or treated a load as a crossing, would show a pending level in the wrong state.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
    typedef enum logic [0:0] {
        TS_ARMED = 1'b0,
        TS_FIRED = 1'b1
    } tcmp_state_e;
endpackage

// File: rtl/tcmp_csr_decode.sv
module tcmp_csr_decode #(
    parameter int ADDR_W  = 12,
    parameter int N_ALIAS = 4,
    parameter logic [N_ALIAS*ADDR_W-1:0] CNT_ALIASES = '0,
    parameter logic [ADDR_W-1:0] CMP_ADDR = '0
) (
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    output logic              cnt_we,
    output logic              cmp_we
);
    logic [N_ALIAS-1:0] alias_hit;

    for (genvar i = 0; i < N_ALIAS; i++) begin : g_alias
        assign alias_hit[i] = (csr_addr == CNT_ALIASES[i*ADDR_W +: ADDR_W]);
    end

    assign cnt_we = csr_we && (|alias_hit);
    assign cmp_we = csr_we && (csr_addr == CMP_ADDR);
endmodule

// File: rtl/tcmp_counter.sv
module tcmp_counter #(
    parameter int COUNT_W = 64,
    parameter int STEP_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [COUNT_W-1:0] load_val,
    input  logic               step_en,
    input  logic [STEP_W-1:0]  step_num,
    output logic [COUNT_W-1:0] count_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (step_en) begin
            count_q <= count_q + COUNT_W'(step_num);
        end
    end
endmodule

// File: rtl/tcmp_cross_detect.sv
module tcmp_cross_detect #(
    parameter int CMP_W  = 32,
    parameter int STEP_W = 4
) (
    input  logic              step_en,
    input  logic [CMP_W-1:0]  low_count,
    input  logic [CMP_W-1:0]  cmp_val,
    input  logic [STEP_W-1:0] step_num,
    output logic              crossed
);
    localparam int SUM_W = CMP_W + 1;

    logic [SUM_W-1:0] full_sum;
    logic             start_le;
    logic             end_ge;

    always_comb begin
        full_sum = {1'b0, low_count} + SUM_W'(step_num);
        start_le = (low_count <= cmp_val);
        end_ge   = (full_sum >= {1'b0, cmp_val});
        crossed  = step_en && start_le && end_ge;
    end
endmodule

// File: rtl/tcmp_timer.sv
module tcmp_timer #(
    parameter int COUNT_W = 64,
    parameter int CMP_W   = 32,
    parameter int STEP_W  = 4,
    parameter int ADDR_W  = 12,
    parameter int N_ALIAS = 4,
    parameter logic [N_ALIAS*ADDR_W-1:0] CNT_ALIASES = {12'h7C0, 12'hC02, 12'hC01, 12'hC00},
    parameter logic [ADDR_W-1:0] CMP_ADDR = 12'h7C1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               retire_valid,
    input  logic [STEP_W-1:0]  retire_num,
    input  logic               csr_we,
    input  logic [ADDR_W-1:0]  csr_addr,
    input  logic [COUNT_W-1:0] csr_wdata,
    output logic [COUNT_W-1:0] count_o,
    output logic [CMP_W-1:0]   compare_o,
    output logic               timer_pend_o
);
    import tcmp_pkg::*;

    logic              cnt_we;
    logic              cmp_we;
    logic              step_en;
    logic              crossed;
    logic [CMP_W-1:0]  cmp_q;
    tcmp_state_e       state_q;
    tcmp_state_e       state_d;

    tcmp_csr_decode #(
        .ADDR_W     (ADDR_W),
        .N_ALIAS    (N_ALIAS),
        .CNT_ALIASES(CNT_ALIASES),
        .CMP_ADDR   (CMP_ADDR)
    ) u_dec (
        .csr_we  (csr_we),
        .csr_addr(csr_addr),
        .cnt_we  (cnt_we),
        .cmp_we  (cmp_we)
    );

    assign step_en = retire_valid && !cnt_we;

    tcmp_counter #(
        .COUNT_W(COUNT_W),
        .STEP_W (STEP_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_we),
        .load_val(csr_wdata),
        .step_en (step_en),
        .step_num(retire_num),
        .count_q (count_o)
    );

    tcmp_cross_detect #(
        .CMP_W (CMP_W),
        .STEP_W(STEP_W)
    ) u_cross (
        .step_en  (step_en),
        .low_count(count_o[CMP_W-1:0]),
        .cmp_val  (cmp_q),
        .step_num (retire_num),
        .crossed  (crossed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_we) begin
            cmp_q <= csr_wdata[CMP_W-1:0];
        end
    end

    // next-state logic: a compare write re-arms and wins over a crossing
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_ARMED: begin
                if (cmp_we)       state_d = TS_ARMED;
                else if (crossed) state_d = TS_FIRED;
            end
            TS_FIRED: begin
                if (cmp_we)       state_d = TS_ARMED;
            end
            default:              state_d = TS_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        compare_o    = cmp_q;
        timer_pend_o = (state_q == TS_FIRED);
    end
endmodule

// File: rtl/tcmp_timer_chk.sv
module tcmp_timer_chk #(
    parameter int COUNT_W = 64,
    parameter int CMP_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cnt_we,
    input logic               cmp_we,
    input logic               retire_valid,
    input logic [COUNT_W-1:0] csr_wdata,
    input logic [COUNT_W-1:0] count_o,
    input logic [CMP_W-1:0]   compare_o,
    input logic               timer_pend_o
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0 && compare_o == '0 && !timer_pend_o))
        else $error("p_reset_r1");

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && !retire_valid) |=> $stable(count_o))
        else $error("p_idle_r2");

    p_cnt_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> count_o == $past(csr_wdata))
        else $error("p_cnt_load_r3");

    p_cnt_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && retire_valid) |=> count_o == $past(csr_wdata))
        else $error("p_cnt_prio_r4");

    p_rise_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_pend_o) |-> $past(retire_valid && !cnt_we && !cmp_we))
        else $error("p_rise_src_r5");

    p_cmp_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> (!timer_pend_o && compare_o == $past(csr_wdata[CMP_W-1:0])))
        else $error("p_cmp_clear_r8");

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_pend_o && !cmp_we) |=> timer_pend_o)
        else $error("p_hold_r9");

    p_no_load_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && !timer_pend_o) |=> !timer_pend_o)
        else $error("p_no_load_fire_r10");
endmodule

bind tcmp_timer tcmp_timer_chk #(
    .COUNT_W(COUNT_W),
    .CMP_W  (CMP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_we      (cnt_we),
    .cmp_we      (cmp_we),
    .retire_valid(retire_valid),
    .csr_wdata   (csr_wdata),
    .count_o     (count_o),
    .compare_o   (compare_o),
    .timer_pend_o(timer_pend_o)
);

// File: tb/tb_tcmp_timer.sv
module tb_tcmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_valid = 1'b0;
    logic [3:0]  retire_num = '0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] count_o;
    logic [31:0] compare_o;
    logic        timer_pend_o;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // reference state
    logic [63:0] m_cnt = '0;
    logic [31:0] m_cmp = '0;
    logic        m_pend = 1'b0;

    always #10 clk = ~clk;

    tcmp_timer dut (
        .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .retire_num(retire_num),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .count_o(count_o), .compare_o(compare_o), .timer_pend_o(timer_pend_o)
    );

    function automatic bit is_cnt_addr(input logic [11:0] a);
        return a == 12'hC00 || a == 12'hC01 || a == 12'hC02 || a == 12'h7C0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_cmp = '0; m_pend = 1'b0;
        end else begin
            bit cw;
            bit pw;
            logic [32:0] s;
            cw = csr_we && is_cnt_addr(csr_addr);
            pw = csr_we && csr_addr == 12'h7C1;
            if (!cw && retire_valid && !pw) begin
                s = {1'b0, m_cnt[31:0]} + 33'(retire_num);
                if (m_cnt[31:0] <= m_cmp && s >= {1'b0, m_cmp}) m_pend = 1'b1;
            end
            if (pw) begin
                m_pend = 1'b0;
                m_cmp  = csr_wdata[31:0];
            end
            if (cw) m_cnt = csr_wdata;
            else if (retire_valid) m_cnt = m_cnt + 64'(retire_num);
        end
    end

    task automatic compare_now();
        n_chk++;
        if (count_o !== m_cnt || compare_o !== m_cmp || timer_pend_o !== m_pend) begin
            n_bad++;
            $display("FAIL %s: count=%h cmp=%h pend=%b expected count=%h cmp=%h pend=%b",
                     cur_req, count_o, compare_o, timer_pend_o, m_cnt, m_cmp, m_pend);
        end
    endtask

    // compare the previous edge's result, then drive the next cycle's inputs
    task automatic cyc(input bit rv, input logic [3:0] n, input bit we,
                       input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        compare_now();
        retire_valid = rv; retire_num = n;
        csr_we = we; csr_addr = a; csr_wdata = d;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        cyc(0, 0, 1, a, d);
    endtask

    task automatic ret(input logic [3:0] n);
        cyc(1, n, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        repeat (3) idle();
        rst_n = 1'b1;
        idle(); idle();

        cur_req = "R3";
        wr(12'hC00, 64'd100); idle();
        wr(12'hC01, 64'd200); idle();
        wr(12'hC02, 64'd300); idle();
        wr(12'h7C0, 64'd400); idle();
        wr(12'h123, 64'd999); idle(); idle();

        cur_req = "R8";
        wr(12'h7C1, 64'h1_0000_0050); idle();

        cur_req = "R5";
        wr(12'hC00, 64'h40);
        for (int i = 0; i < 5; i++) ret(4);
        idle();

        cur_req = "R9";
        for (int i = 0; i < 6; i++) ret(15);
        idle();

        cur_req = "R8";
        wr(12'h7C1, 64'h200); idle();

        cur_req = "R5";
        wr(12'hC00, 64'h1F0); ret(15); idle(); ret(15); idle();
        wr(12'h7C1, 64'h300); wr(12'hC00, 64'h300); ret(0); idle();

        cur_req = "R6";
        wr(12'h7C1, 64'h110); wr(12'hC00, 64'hABCD_0000_0000_0100);
        ret(15); ret(15); idle();

        cur_req = "R7";
        wr(12'h7C1, 64'd5); wr(12'hC00, 64'h0000_0000_FFFF_FFFE);
        ret(9); idle(); idle();
        wr(12'h7C1, 64'hFFFF_FFFF); wr(12'hC00, 64'h0000_0000_FFFF_FFFE);
        ret(3); idle();

        cur_req = "R4";
        cyc(1, 7, 1, 12'hC02, 64'h55); idle();

        cur_req = "R10";
        wr(12'h7C1, 64'h80); wr(12'h7C0, 64'h80); idle(); idle();

        cur_req = "R8";
        wr(12'hC00, 64'h7E); cyc(1, 4, 1, 12'h7C1, 64'h1000); idle();

        cur_req = "R2";
        wr(12'hC00, 64'hFFFF_FFFF_FFFF_FFFF); ret(1); idle(); ret(0); idle();

        cur_req = "R5";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 15);
            if (r == 0)      wr(12'h7C1, {32'h0, 24'h0, 8'($urandom)});
            else if (r == 1) wr(12'hC01, {32'($urandom), 24'h0, 8'($urandom)});
            else if (r == 2) cyc(1, 4'($urandom), 1, 12'hC02, 64'($urandom));
            else if (r == 3) cyc(1, 4'($urandom), 1, 12'h7C1, 64'($urandom_range(0, 255)));
            else if (r < 12) ret(4'($urandom));
            else             idle();
        end
        idle(); idle();
        finish_run();
    end
endmodule